// File: doc/BRIEF.md
# Pin I/O Controller with Per-Pin Four-Condition Interrupts

This block controls a bank of general-purpose pins through a plain 32-bit register port. For every pin, software sets whether the input buffer is on, whether the pad is driven, the value to drive, and an inversion mask applied on the way out. Pad inputs are brought into the clock domain by a chain of synchronizing flops.

On the input side the block watches four conditions per pin: a rising edge, a falling edge, a high level and a low level. Each condition has its own per-pin enable register and its own per-pin sticky pending register. Software clears pending bits by writing ones. Each pin has a dedicated interrupt line, raised when any of its pending conditions is also enabled. The design is meant to sit beside an interrupt controller that takes one line per pin.

Register byte offsets are fixed, because the software that drives the block decodes them. Offset 0x00 is the synchronized input (read-only). 0x04 holds input enables, 0x08 output enables, 0x0C output values and 0x40 the output inversion mask. The condition pairs (enable, pending) sit at 0x18/0x1C for rising edge, 0x20/0x24 for falling edge, 0x28/0x2C for high level and 0x30/0x34 for low level. Bit i of every register belongs to pin i.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: A write (bus_wen high at a clock edge) to 0x04, 0x08, 0x0C, 0x40 or any condition-enable offset stores bus_wdata. Reading that offset afterwards returns the stored value. Only address bits above bit 1 are decoded. Reads of unmapped offsets return 0, and writes to them or to 0x00 change nothing.
- R2: After reset every register holds 0, so irq, pad_oe, pad_out and every register read are 0.
- R3: Reading 0x00 returns the pad input after the two synchronizing flops, ANDed with the input enables. A pad change becomes readable two clock edges after it is applied, and reads 0 on pins whose input enable is 0.
- R4: A rising (falling) edge of the synchronized input sets that pin's rise (fall) pending bit at the next clock edge. This happens only if the pin's input enable is 1. Pending bits are set whether or not the matching condition enable is on.
- R5: Pending bits are sticky. A set bit stays set until software clears it.
- R6: Writing a mask to a pending offset clears exactly the bits that are 1 in the mask. A clear at the same edge as a new event wins.
- R7: The high (low) pending bit is set at every edge at which the enabled, synchronized input was high (low). After a clear it reads 0 for one cycle, then comes back while the level holds.
- R8: irq[i] is 1 exactly when, for some condition, pin i's pending bit and enable bit are both 1. It follows an enable write in the cycle after that write.
- R9: pad_oe equals the output-enable register. pad_out equals (output value XOR inversion mask) on enabled pins and 0 on the others.
- R10: Reading 0x0C returns the stored output value, regardless of the pad inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (7) | Byte address of the register access |
| bus_wen | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pad_in | input | NPINS (32) | Asynchronous pad inputs |
| pad_out | output | NPINS (32) | Value driven onto the pads |
| pad_oe | output | NPINS (32) | Pad drive enable per pin |
| irq | output | NPINS (32) | Interrupt line per pin |

## Verification
The detection logic is exercised with a single pulse on two pins with the input buffers on. This separates the rising-edge and falling-edge paths, and because the pending read is sampled both before and after the capture edge, it also checks the two-flop latency. A constant low bus tests the level path and the one-cycle gap after a clear, and a held-high pin does the same for the high-level path. A pulse on a pin with its input buffer off must leave every condition untouched. A table of write/readback vectors covers the decode, including unmapped and read-only offsets. Single-bit clear masks check that neighbouring pins keep their pending state.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
   localparam int BUS_W = 32;
   localparam int NCOND = 4;

   // condition index: also selects the enable/pending word pair
   typedef enum logic [1:0] {
      C_RISE = 2'd0,
      C_FALL = 2'd1,
      C_HIGH = 2'd2,
      C_LOW  = 2'd3
   } cond_e;

   // word indices (byte offset / 4)
   localparam int WI_INPUT  = 0;
   localparam int WI_IEN    = 1;
   localparam int WI_OEN    = 2;
   localparam int WI_OVAL   = 3;
   localparam int WI_COND0  = 6;   // enable of condition c at WI_COND0 + 2c
   localparam int WI_OXOR   = 16;  // pending sits one word above its enable
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] chain;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '0;
         else if (s == 0) chain[s] <= d;
         else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_cond_unit.sv
module gpio_cond_unit
   import gpio_irq_pkg::*;
#(
   parameter int W = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [W-1:0]           sync_val,
   input  logic [W-1:0]           in_en,
   input  logic [NCOND-1:0][W-1:0] cond_en,
   input  logic [NCOND-1:0][W-1:0] clr,
   output logic [NCOND-1:0][W-1:0] pend,
   output logic [W-1:0]           irq
);
   logic [W-1:0]            prev_q;
   logic [NCOND-1:0][W-1:0] hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= sync_val;
   end

   always_comb begin
      hit[C_RISE] =  sync_val & ~prev_q & in_en;
      hit[C_FALL] = ~sync_val &  prev_q & in_en;
      hit[C_HIGH] =  sync_val & in_en;
      hit[C_LOW]  = ~sync_val & in_en;
   end

   for (genvar c = 0; c < NCOND; c++) begin : g_cond
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pend[c] <= '0;
         else        pend[c] <= (pend[c] | hit[c]) & ~clr[c];
      end
   end

   for (genvar i = 0; i < W; i++) begin : g_pin
      logic [NCOND-1:0] act;
      for (genvar c = 0; c < NCOND; c++) begin : g_act
         assign act[c] = pend[c][i] & cond_en[c][i];
      end
      assign irq[i] = |act;
   end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_irq_pkg::*;
#(
   parameter int W      = 32,
   parameter int ADDR_W = 7
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic                    bus_wen,
   input  logic [BUS_W-1:0]        bus_wdata,
   output logic [BUS_W-1:0]        bus_rdata,
   input  logic [W-1:0]            sync_val,
   input  logic [NCOND-1:0][W-1:0] pend,
   output logic [W-1:0]            in_en,
   output logic [W-1:0]            out_en,
   output logic [W-1:0]            out_val,
   output logic [W-1:0]            out_xor,
   output logic [NCOND-1:0][W-1:0] cond_en,
   output logic [NCOND-1:0][W-1:0] clr
);
   localparam int IDX_W = ADDR_W - 2;

   logic [IDX_W-1:0] widx;
   logic [1:0]       unused_lane;
   logic [W-1:0]     wd;

   assign widx        = bus_addr[ADDR_W-1:2];
   assign unused_lane = bus_addr[1:0];
   assign wd          = bus_wdata[W-1:0];

   function automatic logic hit_word(input logic [IDX_W-1:0] idx, input int target);
      return int'(idx) == target;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_en   <= '0;
         out_en  <= '0;
         out_val <= '0;
         out_xor <= '0;
      end else if (bus_wen) begin
         if (hit_word(widx, WI_IEN))  in_en   <= wd;
         if (hit_word(widx, WI_OEN))  out_en  <= wd;
         if (hit_word(widx, WI_OVAL)) out_val <= wd;
         if (hit_word(widx, WI_OXOR)) out_xor <= wd;
      end
   end

   for (genvar c = 0; c < NCOND; c++) begin : g_cond
      localparam int EN_IDX = WI_COND0 + 2*c;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                cond_en[c] <= '0;
         else if (bus_wen && hit_word(widx, EN_IDX)) cond_en[c] <= wd;
      end
      assign clr[c] = (bus_wen && hit_word(widx, EN_IDX + 1)) ? wd : '0;
   end

   always_comb begin
      bus_rdata = '0;
      if (hit_word(widx, WI_INPUT)) bus_rdata = BUS_W'(sync_val & in_en);
      if (hit_word(widx, WI_IEN))   bus_rdata = BUS_W'(in_en);
      if (hit_word(widx, WI_OEN))   bus_rdata = BUS_W'(out_en);
      if (hit_word(widx, WI_OVAL))  bus_rdata = BUS_W'(out_val);
      if (hit_word(widx, WI_OXOR))  bus_rdata = BUS_W'(out_xor);
      for (int c = 0; c < NCOND; c++) begin
         if (hit_word(widx, WI_COND0 + 2*c))     bus_rdata = BUS_W'(cond_en[c]);
         if (hit_word(widx, WI_COND0 + 2*c + 1)) bus_rdata = BUS_W'(pend[c]);
      end
   end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
   import gpio_irq_pkg::*;
#(
   parameter int NPINS       = 32,
   parameter int ADDR_W      = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wen,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [NPINS-1:0]  pad_in,
   output logic [NPINS-1:0]  pad_out,
   output logic [NPINS-1:0]  pad_oe,
   output logic [NPINS-1:0]  irq
);
   if (NPINS < 1 || NPINS > BUS_W) begin : g_bad_npins
      $error("gpio_irq_ctrl: NPINS must be within 1..32");
   end
   if (ADDR_W < 7) begin : g_bad_addr
      $error("gpio_irq_ctrl: ADDR_W must reach offset 0x40");
   end

   logic [NPINS-1:0]            sync_val;
   logic [NPINS-1:0]            ien_q, oen_q, oval_q, oxor_q;
   logic [NCOND-1:0][NPINS-1:0] cen_q, pend_q, clr_v;

   gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(sync_val)
   );

   gpio_regs #(.W(NPINS), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_addr(bus_addr), .bus_wen(bus_wen), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .sync_val(sync_val), .pend(pend_q),
      .in_en(ien_q), .out_en(oen_q), .out_val(oval_q), .out_xor(oxor_q),
      .cond_en(cen_q), .clr(clr_v)
   );

   gpio_cond_unit #(.W(NPINS)) u_cond (
      .clk(clk), .rst_n(rst_n),
      .sync_val(sync_val), .in_en(ien_q), .cond_en(cen_q), .clr(clr_v),
      .pend(pend_q), .irq(irq)
   );

   assign pad_oe  = oen_q;
   assign pad_out = (oval_q ^ oxor_q) & oen_q;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
   parameter int NPINS  = 32,
   parameter int ADDR_W = 7,
   parameter int NCOND  = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [ADDR_W-1:0]      bus_addr,
   input logic                   bus_wen,
   input logic [31:0]            bus_wdata,
   input logic [NPINS-1:0]       pad_oe,
   input logic [NPINS-1:0]       irq,
   input logic [NPINS-1:0]       ien,
   input logic [NCOND*NPINS-1:0] pend,
   input logic [NCOND*NPINS-1:0] clr
);
   logic [NPINS-1:0] any_pend;
   always_comb begin
      any_pend = '0;
      for (int c = 0; c < NCOND; c++) any_pend |= pend[c*NPINS +: NPINS];
   end

   // R4, R7: a newly set pending bit needs the pin's input enable
   a_r4_detect_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend & ~$past(pend) & ~{NCOND{$past(ien)}}) == '0));

   // R5: pending bits are never lost without a clear
   a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(pend) & ~$past(clr) & ~pend) == '0));

   // R6: a cleared bit reads 0 after the clearing edge
   a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend & $past(clr)) == '0));

   // R8: an interrupt line needs some pending condition on its pin
   a_r8_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq & ~any_pend) == '0));

   // R9: the drive enable follows a write of the output-enable word
   a_r9_oe_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wen && (int'(bus_addr[ADDR_W-1:2]) == 2)) |=> (pad_oe == $past(bus_wdata[NPINS-1:0])));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W), .NCOND(4)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen), .bus_wdata(bus_wdata),
   .pad_oe(pad_oe), .irq(irq), .ien(ien_q), .pend(pend_q), .clr(clr_v)
);

// File: tb/tb_gpio_irq_ctrl.sv
module tb_gpio_irq_ctrl;
   localparam int NV = 11;
   localparam logic [6:0]  T_ADDR [NV] = '{7'h08, 7'h0C, 7'h40, 7'h18, 7'h20, 7'h28, 7'h30,
                                           7'h00, 7'h10, 7'h44, 7'h1C};
   localparam logic [31:0] T_WD   [NV] = '{32'h1234_5678, 32'hDEAD_BEEF, 32'h0F0F_F0F0,
                                           32'h0000_00FF, 32'h0000_FF00, 32'h00FF_0000,
                                           32'hFF00_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
                                           32'hAAAA_AAAA, 32'hFFFF_FFFF};
   localparam logic [31:0] T_EXP  [NV] = '{32'h1234_5678, 32'hDEAD_BEEF, 32'h0F0F_F0F0,
                                           32'h0000_00FF, 32'h0000_FF00, 32'h00FF_0000,
                                           32'hFF00_0000, 32'h0, 32'h0, 32'h0, 32'h0};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [6:0]  bus_addr = '0;
   logic        bus_wen = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pad_in = '0;
   logic [31:0] pad_out, pad_oe, irq;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   gpio_irq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [6:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
      @(negedge clk);
      bus_wen = 1'b0;
   endtask

   task automatic rd(input logic [6:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      wait_n(3);
      rst_n = 1'b1;
      wait_n(1);

      // R2: reset state
      check("R2 irq", irq, 32'h0);
      check("R2 pad_oe", pad_oe, 32'h0);
      rd(7'h0C, v); check("R2 oval", v, 32'h0);
      rd(7'h34, v); check("R2 low pending", v, 32'h0);

      // R1: table of write/readback vectors
      for (int i = 0; i < NV; i++) begin
         wr(T_ADDR[i], T_WD[i]);
         rd(T_ADDR[i], v);
         check($sformatf("R1 vec%0d", i), v, T_EXP[i]);
      end

      // R9: pad drive from value, mask and enable
      check("R9 pad_out", pad_out, 32'h1020_4618);
      check("R9 pad_oe", pad_oe, 32'h1234_5678);

      // R10: output value read ignores pads
      pad_in = 32'hFFFF_FFFF;
      wait_n(3);
      rd(7'h0C, v); check("R10 oval", v, 32'hDEAD_BEEF);
      pad_in = '0;
      foreach (T_ADDR[i]) if (i < 7) wr(T_ADDR[i], 32'h0);
      check("R9 pad_out off", pad_out, 32'h0);

      // R7, R8: low level with buffers on
      wr(7'h04, 32'hFFFF_FFFF);
      wait_n(2);
      rd(7'h34, v); check("R7 low pending", v, 32'hFFFF_FFFF);
      check("R8 not enabled", irq, 32'h0);
      wr(7'h30, 32'h0000_0008);
      check("R8 low irq", irq, 32'h0000_0008);
      wr(7'h30, 32'h0);
      wr(7'h34, 32'hFFFF_FFFF);
      rd(7'h34, v); check("R7 gap after clear", v, 32'h0);
      wait_n(1);
      rd(7'h34, v); check("R7 low reasserts", v, 32'hFFFF_FFFF);

      // R3, R4: rising edge on pins 0 and 4
      pad_in = 32'h0000_0011;
      wait_n(2);
      rd(7'h00, v); check("R3 input value", v, 32'h0000_0011);
      rd(7'h1C, v); check("R4 rise not yet", v, 32'h0);
      wait_n(1);
      rd(7'h1C, v); check("R4 rise pending", v, 32'h0000_0011);
      rd(7'h24, v); check("R4 no fall", v, 32'h0);

      // R5: falling edge, rise stays
      pad_in = '0;
      wait_n(3);
      rd(7'h1C, v); check("R5 rise sticky", v, 32'h0000_0011);
      rd(7'h24, v); check("R4 fall pending", v, 32'h0000_0011);

      // R6: single-bit clear
      wr(7'h1C, 32'h0000_0001);
      rd(7'h1C, v); check("R6 one bit cleared", v, 32'h0000_0010);
      rd(7'h24, v); check("R6 fall untouched", v, 32'h0000_0011);

      // R8: enable then clear
      wr(7'h18, 32'h0000_0010);
      check("R8 rise irq", irq, 32'h0000_0010);
      wr(7'h1C, 32'h0000_0010);
      check("R8 irq drops", irq, 32'h0);

      // R3, R4: pin 8 buffer off
      wr(7'h04, 32'hFFFF_FEFF);
      pad_in = 32'h0000_0100;
      wait_n(3);
      rd(7'h00, v); check("R3 buffer off", v, 32'h0);
      rd(7'h1C, v); check("R4 ignored rise", v, 32'h0);
      pad_in = '0;
      wait_n(3);
      rd(7'h24, v); check("R4 ignored fall", v, 32'h0000_0011);

      // R7: high level clear and reassert
      wr(7'h2C, 32'hFFFF_FFFF);
      pad_in = 32'h0000_0020;
      wait_n(3);
      rd(7'h2C, v); check("R7 high pending", v, 32'h0000_0020);
      wr(7'h2C, 32'h0000_0020);
      rd(7'h2C, v); check("R7 high gap", v, 32'h0);
      wait_n(1);
      rd(7'h2C, v); check("R7 high reasserts", v, 32'h0000_0020);
      wr(7'h28, 32'h0000_0020);
      check("R8 high irq", irq, 32'h0000_0020);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule